// File: doc/BRIEF.md
# Correctable error profiling monitor

This block sits beside the SECDED decoder of a memory and watches the error reports that the decoder produces on each access. It does not touch the data path, so correction continues whatever state its registers are in. Each single-bit report is counted. The first report after a release is captured with its address and failing bit position. Single-cycle event pulses go to a system error collector when the count reaches a programmed threshold, or at once when a bit of a chosen polarity fails. Double-bit reports are captured in their own frozen address register and raise an uncorrectable event.

Software reaches the block through a small word-wide register port with a combinational read path. A capture register stays frozen until software reads its address register. That read also re-arms the event path that belongs to it. Events leave the block only while a 4-bit key field holds the enabling value.

Top module: `ecc_err_monitor`

## Requirements
- R1: Each accepted single-bit report adds one to the counter (register 2). The counter holds at its all-ones maximum, and any write to register 2 clears it to zero.
- R2: When profile enable (control bit 4) is set and a report takes the counter to exactly the threshold (register 1), `cor_evt_o` pulses high for one cycle, one cycle after the report. Reports that take the counter past the threshold raise no threshold event.
- R3: When ones-fail enable (control bit 5) is set, a single-bit report with `pol_one_i`=1 (a stored 1 read as 0) raises `cor_evt_o`, whatever the counter value and whatever the profile enable.
- R4: When zeros-fail enable (control bit 6) is set, a single-bit report with `pol_one_i`=0 (a stored 0 read as 1) raises `cor_evt_o` in the same way.
- R5: The address (register 4) and bit position (register 5) of the first single-bit report are captured and then frozen. After a correctable event fires, further correctable events are blocked. A read of register 4 releases the capture and re-arms the event path.
- R6: A double-bit report captures its address in register 6 and pulses `unc_evt_o`. Later double-bit reports neither recapture nor raise an event until register 6 is read.
- R7: Counting and status updates continue while the capture registers are frozen or events are blocked.
- R8: An event reaches `cor_evt_o` or `unc_evt_o` only while control bits [3:0] equal 0xA.
- R9: A report with `chk_space_i`=1 changes no counter, status bit, capture register or event.
- R10: The status register (3) resets to 0. Its bits are: bit 0 single-bit seen, bit 1 double-bit seen, bit 2 ones-fail seen, bit 3 zeros-fail seen. Writing 1 to a bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sbe_i | input | 1 | Single-bit error report, one cycle per access |
| dbe_i | input | 1 | Double-bit error report, one cycle per access |
| chk_space_i | input | 1 | Report comes from the check-bit address space |
| pol_one_i | input | 1 | 1: stored 1 read as 0; 0: stored 0 read as 1 |
| err_addr_i | input | AW | Address of the failing access |
| err_pos_i | input | POS_W | Failing bit position |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_sel_i | input | 3 | Register index |
| reg_wdata_i | input | REG_W | Write data |
| reg_rdata_o | output | REG_W | Read data, combinational from reg_sel_i |
| cor_evt_o | output | 1 | Correctable event pulse |
| unc_evt_o | output | 1 | Uncorrectable event pulse |

## Verification
The assertions assume that each report arrives as a single-cycle pulse, and that single-bit and double-bit reports never come in the same cycle as a write to the register they affect. They also assume that a release read never lands in the same cycle as a new report. The stimulus keeps to this by giving each cycle either one report or one register access, never both. Address and bit values change every report, so a stale or wrongly overwritten capture shows up on readback.

// File: rtl/ecc_mon_pkg.sv
package ecc_mon_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL     = 3'd0,
    SEL_THR      = 3'd1,
    SEL_CNT      = 3'd2,
    SEL_STAT     = 3'd3,
    SEL_COR_ADDR = 3'd4,
    SEL_COR_POS  = 3'd5,
    SEL_UNC_ADDR = 3'd6
  } reg_sel_e;

  localparam logic [3:0] EVT_KEY = 4'hA;
  localparam int CTRL_W = 7;
  localparam int STAT_W = 4;

  typedef struct packed {
    logic       zeros_en;
    logic       ones_en;
    logic       prof_en;
    logic [3:0] key;
  } ctrl_t;

  typedef struct packed {
    logic zeros_seen;
    logic ones_seen;
    logic dbe_seen;
    logic sbe_seen;
  } stat_t;
endpackage

// File: rtl/ecc_mon_counter.sv
module ecc_mon_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);
  assign hit_o  = inc_i && !clr_i && !at_max && ((cnt_q + 1'b1) == thr_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (inc_i && !at_max) cnt_q <= cnt_q + 1'b1;
  end

  p_sat_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_max && inc_i && !clr_i) |=> (cnt_q == CNT_MAX));
  p_inc_one_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !at_max) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_clr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/ecc_mon_capture.sv
module ecc_mon_capture #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] data_i,
  input  logic         rel_i,
  output logic [W-1:0] data_o,
  output logic         frozen_o
);
  logic [W-1:0] data_q;
  logic         frozen_q;
  logic         take;

  // a release read has priority; a report in that same cycle is dropped
  assign take = cap_i && !frozen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      frozen_q <= 1'b0;
    end else begin
      if (take) data_q <= data_i;
      if (take)       frozen_q <= 1'b1;
      else if (rel_i) frozen_q <= 1'b0;
    end
  end

  assign data_o   = data_q;
  assign frozen_o = frozen_q;

  p_frozen_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_q && !rel_i) |=> $stable(data_q));
  p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !frozen_q) |=> (frozen_q && data_q == $past(data_i)));
endmodule

// File: rtl/ecc_err_monitor.sv
module ecc_err_monitor
  import ecc_mon_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DATA_BITS = 72,
  parameter int CNT_W     = 16,
  parameter int REG_W     = 16,
  localparam int POS_W    = $clog2(DATA_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sbe_i,
  input  logic             dbe_i,
  input  logic             chk_space_i,
  input  logic             pol_one_i,
  input  logic [AW-1:0]    err_addr_i,
  input  logic [POS_W-1:0] err_pos_i,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [2:0]       reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             cor_evt_o,
  output logic             unc_evt_o
);
  localparam int COR_W = AW + POS_W;

  ctrl_t            ctrl_q;
  stat_t            stat_q, stat_set;
  logic [CNT_W-1:0] thr_q, cnt;
  logic             thr_hit;
  logic             sbe_ok, dbe_ok, key_ok;
  logic             wr_ctrl, wr_thr, wr_cnt, wr_stat, rd_cor, rd_unc;
  logic [COR_W-1:0] cor_data;
  logic             cor_frozen, unc_frozen;
  logic [AW-1:0]    unc_addr;
  logic             cor_blk_q, cor_trig, cor_fire, unc_fire;

  assign sbe_ok  = sbe_i && !chk_space_i;
  assign dbe_ok  = dbe_i && !chk_space_i;
  assign key_ok  = (ctrl_q.key == EVT_KEY);
  assign wr_ctrl = reg_we_i && (reg_sel_i == SEL_CTRL);
  assign wr_thr  = reg_we_i && (reg_sel_i == SEL_THR);
  assign wr_cnt  = reg_we_i && (reg_sel_i == SEL_CNT);
  assign wr_stat = reg_we_i && (reg_sel_i == SEL_STAT);
  assign rd_cor  = reg_re_i && (reg_sel_i == SEL_COR_ADDR);
  assign rd_unc  = reg_re_i && (reg_sel_i == SEL_UNC_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      thr_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
      if (wr_thr)  thr_q  <= reg_wdata_i[CNT_W-1:0];
    end
  end

  ecc_mon_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (sbe_ok),
    .clr_i (wr_cnt),
    .thr_i (thr_q),
    .cnt_o (cnt),
    .hit_o (thr_hit)
  );

  ecc_mon_capture #(.W(COR_W)) u_cor_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (sbe_ok),
    .data_i  ({err_pos_i, err_addr_i}),
    .rel_i   (rd_cor),
    .data_o  (cor_data),
    .frozen_o(cor_frozen)
  );

  ecc_mon_capture #(.W(AW)) u_unc_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (dbe_ok),
    .data_i  (err_addr_i),
    .rel_i   (rd_unc),
    .data_o  (unc_addr),
    .frozen_o(unc_frozen)
  );

  // status: set wins over a same-cycle write-1-to-clear
  always_comb begin
    stat_set            = '0;
    stat_set.sbe_seen   = sbe_ok;
    stat_set.dbe_seen   = dbe_ok;
    stat_set.ones_seen  = sbe_ok && pol_one_i;
    stat_set.zeros_seen = sbe_ok && !pol_one_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else stat_q <= (stat_q & ~(wr_stat ? stat_t'(reg_wdata_i[STAT_W-1:0]) : stat_t'('0)))
                   | stat_set;
  end

  assign cor_trig = (ctrl_q.prof_en && thr_hit)
                  || (ctrl_q.ones_en && sbe_ok && pol_one_i)
                  || (ctrl_q.zeros_en && sbe_ok && !pol_one_i);
  assign cor_fire = key_ok && cor_trig && !cor_blk_q;
  assign unc_fire = key_ok && dbe_ok && !unc_frozen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cor_blk_q <= 1'b0;
      cor_evt_o <= 1'b0;
      unc_evt_o <= 1'b0;
    end else begin
      cor_evt_o <= cor_fire;
      unc_evt_o <= unc_fire;
      if (cor_fire)    cor_blk_q <= 1'b1;
      else if (rd_cor) cor_blk_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_sel_i)
      SEL_CTRL:     reg_rdata_o = REG_W'(ctrl_q);
      SEL_THR:      reg_rdata_o = REG_W'(thr_q);
      SEL_CNT:      reg_rdata_o = REG_W'(cnt);
      SEL_STAT:     reg_rdata_o = REG_W'(stat_q);
      SEL_COR_ADDR: reg_rdata_o = REG_W'(cor_data[AW-1:0]);
      SEL_COR_POS:  reg_rdata_o = REG_W'(cor_data[COR_W-1:AW]);
      SEL_UNC_ADDR: reg_rdata_o = REG_W'(unc_addr);
      default:      reg_rdata_o = '0;
    endcase
  end

  p_key_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cor_evt_o || unc_evt_o) |-> ($past(ctrl_q.key) == EVT_KEY));
  p_chk_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_space_i && !reg_we_i) |=> ($stable(cnt) && $stable(stat_q) && !cor_evt_o && !unc_evt_o));
  p_unc_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unc_evt_o |=> !unc_evt_o);
  p_cor_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cor_evt_o |=> !cor_evt_o);
  p_keep_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbe_ok && cor_frozen && !wr_cnt && cnt != {CNT_W{1'b1}}) |=> (cnt != $past(cnt)));
endmodule

// File: tb/ecc_err_monitor_bench.sv
module ecc_err_monitor_bench;
  localparam int AW = 16;
  localparam int POS_W = 7;
  localparam int REG_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sbe = 0, dbe = 0, chk = 0, pol = 0, we = 0, re = 0;
  logic [AW-1:0] addr = '0;
  logic [POS_W-1:0] pos = '0;
  logic [2:0] sel = '0;
  logic [REG_W-1:0] wd = '0, rdata;
  logic cor_evt, unc_evt;

  int checks = 0;
  int failures = 0;
  bit run = 0;

  typedef struct {
    bit    cor;
    bit    unc;
    string req;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  ecc_err_monitor #(.AW(AW), .DATA_BITS(72), .CNT_W(4), .REG_W(REG_W)) u_ecc_err_monitor (
    .clk_i(clk), .rst_ni(rst_n), .sbe_i(sbe), .dbe_i(dbe), .chk_space_i(chk),
    .pol_one_i(pol), .err_addr_i(addr), .err_pos_i(pos), .reg_we_i(we),
    .reg_re_i(re), .reg_sel_i(sel), .reg_wdata_i(wd), .reg_rdata_o(rdata),
    .cor_evt_o(cor_evt), .unc_evt_o(unc_evt)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic drive(bit s, bit d, bit c, bit p, logic [AW-1:0] a, logic [POS_W-1:0] b,
                       bit w, bit r, logic [2:0] rs, logic [REG_W-1:0] data,
                       bit ec, bit eu, string req);
    @(negedge clk);
    sbe = s; dbe = d; chk = c; pol = p; addr = a; pos = b;
    we = w; re = r; sel = rs; wd = data;
    exp_q.push_back('{ec, eu, req});
  endtask

  task automatic single(logic [AW-1:0] a, logic [POS_W-1:0] b, bit p, bit c, bit ec, string req);
    drive(1, 0, c, p, a, b, 0, 0, 3'd0, '0, ec, 0, req);
  endtask

  task automatic double(logic [AW-1:0] a, bit c, bit eu, string req);
    drive(0, 1, c, 0, a, '0, 0, 0, 3'd0, '0, 0, eu, req);
  endtask

  task automatic wr(logic [2:0] rs, logic [REG_W-1:0] data);
    drive(0, 0, 0, 0, '0, '0, 1, 0, rs, data, 0, 0, "write");
  endtask

  task automatic rd(logic [2:0] rs, logic [REG_W-1:0] expv, string req);
    drive(0, 0, 0, 0, '0, '0, 0, 1, rs, '0, 0, 0, req);
    #1;
    check(req, 32'(rdata), 32'(expv));
  endtask

  // monitor: pops one expected event pair per driven cycle
  initial begin
    wait (run);
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        check({it.req, " cor_evt"}, 32'(cor_evt), 32'(it.cor));
        check({it.req, " unc_evt"}, 32'(unc_evt), 32'(it.unc));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;
    rd(3'd3, 16'h0, "R10 reset status");
    rd(3'd2, 16'h0, "R1 reset count");
    wr(3'd0, 16'h1A);
    wr(3'd1, 16'h2);
    single(16'h0100, 7'd5, 0, 0, 0, "R2 below threshold");
    rd(3'd2, 16'h1, "R1 count one");
    single(16'h0200, 7'd7, 0, 0, 1, "R2 threshold reached");
    rd(3'd5, 16'h5, "R5 bit position frozen");
    rd(3'd4, 16'h0100, "R5 first address frozen");
    single(16'h0400, 7'd9, 1, 1, 0, "R9 check-space single");
    double(16'h0410, 1, 0, "R9 check-space double");
    rd(3'd2, 16'h2, "R9 count unchanged");
    rd(3'd3, 16'h9, "R9 status unchanged");
    single(16'h0300, 7'd3, 0, 0, 0, "R2 past threshold");
    rd(3'd4, 16'h0300, "R9 no capture from check space");
    wr(3'd0, 16'h2A);
    single(16'h0310, 7'd1, 1, 0, 1, "R3 ones fail");
    single(16'h0320, 7'd2, 1, 0, 0, "R5 event blocked");
    rd(3'd2, 16'h5, "R7 counting while blocked");
    rd(3'd4, 16'h0310, "R5 capture held");
    single(16'h0330, 7'd4, 0, 0, 0, "R3 zeros not enabled");
    single(16'h0340, 7'd6, 1, 0, 1, "R3 ones fail after release");
    rd(3'd4, 16'h0330, "R5 recapture after release");
    wr(3'd0, 16'h4A);
    single(16'h0350, 7'd8, 0, 0, 1, "R4 zeros fail");
    rd(3'd4, 16'h0350, "R5 zeros capture");
    wr(3'd0, 16'h25);
    single(16'h0360, 7'd10, 1, 0, 0, "R8 wrong key cor");
    rd(3'd4, 16'h0360, "R7 capture without event");
    double(16'h0050, 0, 0, "R8 wrong key unc");
    rd(3'd6, 16'h0050, "R6 unc capture");
    wr(3'd0, 16'h0A);
    double(16'h0060, 0, 1, "R6 unc event");
    double(16'h0070, 0, 0, "R6 unc blocked");
    rd(3'd6, 16'h0060, "R6 unc frozen");
    double(16'h0080, 0, 1, "R6 unc after release");
    rd(3'd6, 16'h0080, "R6 unc recapture");
    rd(3'd2, 16'h9, "R7 total count");
    rd(3'd3, 16'hF, "R10 all status bits");
    wr(3'd3, 16'h5);
    rd(3'd3, 16'hA, "R10 write-1-to-clear");
    wr(3'd2, 16'h0);
    rd(3'd2, 16'h0, "R1 count cleared");
    wr(3'd0, 16'h0);
    for (int i = 0; i < 17; i++) single(16'(i), 7'd0, 0, 0, 0, "R1 saturation run");
    rd(3'd2, 16'hF, "R1 saturated");
    drive(0, 0, 0, 0, '0, '0, 0, 0, 3'd0, '0, 0, 0, "idle");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule